// File: doc/BRIEF.md
# Selection Reduction Tree

This block is a global reduction network for an array of processing cells. Every cell has one select bit and a stored triple: a data value and the lower and upper bounds of an index interval. The block reads all select bits and all triples as one wide input. When `start` is high it computes three answers at once:

- the number of cells whose select bit is set;
- a new select vector that keeps only the leftmost set bit, together with a flag that says whether any bit was set;
- the triple of that leftmost selected cell, or an explicit "no cell" result.

The network is a binary tree with one leaf per cell. Each leaf turns its cell into a tree node. Each level of the tree merges pairs of nodes and holds the result in one register stage. The tree therefore returns a new result on every cycle, and each result arrives a fixed number of cycles after its issue. The controller of the cell array issues an operation, waits for `done`, and then writes `sel_out` back into the cells' select flags or uses the count and the read-out triple.

Top module: `rt_select_tree`

## Requirements
- R1: When `done` is high, `count` equals the number of 1 bits in the `sel_in` vector of the matching issue. `count` is log2(CELLS)+1 bits wide, so the all-ones vector reports CELLS.
- R2: When `done` is high, `sel_out` holds only the lowest-numbered set bit of the issued `sel_in`, and every other bit is 0. Bit i of each vector belongs to cell i, and cell 0 is the leftmost cell.
- R3: When `done` is high, `any` is 1 exactly when the issued `sel_in` had at least one bit set.
- R4: When `done` is high and a bit was set, `rd_valid` is 1 and `rd_val`, `rd_lo`, `rd_hi` equal the triple of the leftmost selected cell. This also holds when several bits are set. Cell i's triple sits at slice i of each packed input: bits [i*VAL_W +: VAL_W] of `cell_val`, and bits [i*IDX_W +: IDX_W] of `cell_lo` and `cell_hi`.
- R5: When `done` is high and no bit was set, `rd_valid` is 0, `count` is 0, `sel_out` is all zero and the read-out fields are all zero.
- R6: If `start` is high in cycle t, `done` is high in cycle t+log2(CELLS) and shows that issue's result. Issues in consecutive cycles each produce their own result in consecutive cycles.
- R7: While reset is high and in the cycle after it, `done`, `count`, `any`, `sel_out` and `rd_valid` are all 0.
- R8: `sel_in` and cell data that change while `start` is low never make `done` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue the operation on the current inputs |
| sel_in | input | CELLS | Select bit of each cell, bit i = cell i |
| cell_val | input | CELLS*VAL_W | Packed data values, cell i at slice i |
| cell_lo | input | CELLS*IDX_W | Packed interval lower bounds |
| cell_hi | input | CELLS*IDX_W | Packed interval upper bounds |
| done | output | 1 | Result of an issue is valid this cycle |
| count | output | IDX_W+1 | Number of selected cells |
| any | output | 1 | At least one cell was selected |
| sel_out | output | CELLS | Select vector with only the leftmost set bit kept |
| rd_valid | output | 1 | Read-out triple is valid (a cell was selected) |
| rd_val | output | VAL_W | Data value of the leftmost selected cell |
| rd_lo | output | IDX_W | Lower bound of that cell |
| rd_hi | output | IDX_W | Upper bound of that cell |

## Verification
A merge stage that loses or double-counts a subtree shows up as a wrong `count` in the very `done` cycle of the affected issue. A left/right priority swap in a merge stage shows up in that same cycle as a `sel_out` bit and a read-out triple that belong to a cell further right. A valid bit that slips through the register chain moves `done` away from cycle t+log2(CELLS). The reference model catches this on the first issue, because it expects a result in every cycle and predicts `done` low in all other cycles. Back-to-back issues with different patterns expose stale pipeline contents within one cycle.

// File: rtl/rtree_pkg.sv
package rtree_pkg;

    // Array geometry; CELLS must be a power of two, at least 2
    parameter int unsigned CELLS  = 8;
    parameter int unsigned VAL_W  = 16;

    localparam int unsigned IDX_W  = $clog2(CELLS);
    localparam int unsigned CNT_W  = IDX_W + 1;
    localparam int unsigned LEVELS = IDX_W;

    // One node of the reduction tree: summary of a contiguous span of cells
    typedef struct packed {
        logic [CNT_W-1:0] cnt;   // selected cells in span
        logic             any;   // span holds a selected cell
        logic [IDX_W-1:0] idx;   // absolute index of leftmost selected cell
        logic [VAL_W-1:0] v;     // its data value
        logic [IDX_W-1:0] lo;    // its lower bound
        logic [IDX_W-1:0] hi;    // its upper bound
    } node_t;

    // Combine a left span with the adjacent right span; left wins priority
    function automatic node_t merge_nodes(input node_t left, input node_t right);
        node_t m;
        m     = left.any ? left : right;
        m.cnt = left.cnt + right.cnt;
        m.any = left.any | right.any;
        return m;
    endfunction

    // Decode an index into a one-hot cell mask, gated by a presence flag
    function automatic logic [CELLS-1:0] idx_mask(input logic present,
                                                  input logic [IDX_W-1:0] idx);
        logic [CELLS-1:0] m;
        m = '0;
        if (present) m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rt_leaf.sv
module rt_leaf
    import rtree_pkg::*;
#(
    parameter int unsigned POS = 0
) (
    input  logic             sel,
    input  logic [VAL_W-1:0] val,
    input  logic [IDX_W-1:0] lo,
    input  logic [IDX_W-1:0] hi,
    output node_t            node
);

    // An unselected cell contributes a zero payload, so an empty tree yields zeros
    always_comb begin
        node     = '0;
        node.cnt = CNT_W'(sel);
        node.any = sel;
        if (sel) begin
            node.idx = IDX_W'(POS);
            node.v   = val;
            node.lo  = lo;
            node.hi  = hi;
        end
    end

endmodule

// File: rtl/rt_level.sv
module rt_level
    import rtree_pkg::*;
#(
    parameter int unsigned IN_NODES = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       valid_in,
    input  node_t [IN_NODES-1:0]       nin,
    output logic                       valid_out,
    output node_t [IN_NODES/2-1:0]     nout
);

    localparam int unsigned OUT_NODES = IN_NODES / 2;

    node_t [OUT_NODES-1:0] merged;

    generate
        for (genvar j = 0; j < OUT_NODES; j++) begin : g_pair
            assign merged[j] = merge_nodes(nin[2*j], nin[2*j+1]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            nout      <= '0;
            valid_out <= 1'b0;
        end else begin
            nout      <= merged;
            valid_out <= valid_in;
        end
    end

    // Totals on both sides of the register, for the stage checks
    logic [CNT_W-1:0] sum_in, sum_out;
    logic             any_in, any_out;

    always_comb begin
        sum_in = '0;
        any_in = 1'b0;
        for (int i = 0; i < int'(IN_NODES); i++) begin
            sum_in = sum_in + nin[i].cnt;
            any_in = any_in | nin[i].any;
        end
        sum_out = '0;
        any_out = 1'b0;
        for (int i = 0; i < int'(OUT_NODES); i++) begin
            sum_out = sum_out + nout[i].cnt;
            any_out = any_out | nout[i].any;
        end
    end

    // R1
    cnt_conserve_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sum_out == $past(sum_in)));

    // R3
    any_conserve_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (any_out == $past(any_in)));

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (valid_out == $past(valid_in)));

endmodule

// File: rtl/rt_readout.sv
module rt_readout
    import rtree_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             root_valid,
    input  node_t            root,
    output logic             done,
    output logic [CNT_W-1:0] count,
    output logic             any,
    output logic [CELLS-1:0] sel_out,
    output logic             rd_valid,
    output logic [VAL_W-1:0] rd_val,
    output logic [IDX_W-1:0] rd_lo,
    output logic [IDX_W-1:0] rd_hi
);

    always_comb begin
        done     = root_valid;
        count    = root.cnt;
        any      = root.any;
        sel_out  = idx_mask(root.any, root.idx);
        rd_valid = root.any;
        rd_val   = root.v;
        rd_lo    = root.lo;
        rd_hi    = root.hi;
    end

    // R3
    any_vs_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (any == (count != '0)));

    // R2
    single_keep_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(sel_out) == (count != '0 ? 1 : 0)));

    // R5
    none_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && count == '0) |-> (!rd_valid && rd_val == '0 && rd_lo == '0 && rd_hi == '0));

endmodule

// File: rtl/rt_select_tree.sv
module rt_select_tree
    import rtree_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [CELLS-1:0]         sel_in,
    input  logic [CELLS*VAL_W-1:0]   cell_val,
    input  logic [CELLS*IDX_W-1:0]   cell_lo,
    input  logic [CELLS*IDX_W-1:0]   cell_hi,
    output logic                     done,
    output logic [CNT_W-1:0]         count,
    output logic                     any,
    output logic [CELLS-1:0]         sel_out,
    output logic                     rd_valid,
    output logic [VAL_W-1:0]         rd_val,
    output logic [IDX_W-1:0]         rd_lo,
    output logic [IDX_W-1:0]         rd_hi
);

    // stg[k] holds the CELLS>>k nodes of tree level k; upper entries unused
    node_t [CELLS-1:0] stg [LEVELS+1];
    logic  [LEVELS:0]  vld;

    assign vld[0] = start;

    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_leaf
            rt_leaf #(.POS(i)) u_leaf (
                .sel  (sel_in[i]),
                .val  (cell_val[i*VAL_W +: VAL_W]),
                .lo   (cell_lo[i*IDX_W +: IDX_W]),
                .hi   (cell_hi[i*IDX_W +: IDX_W]),
                .node (stg[0][i])
            );
        end

        for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
            localparam int unsigned NIN  = CELLS >> k;
            localparam int unsigned NOUT = NIN / 2;
            rt_level #(.IN_NODES(NIN)) u_level (
                .clk       (clk),
                .rst       (rst),
                .valid_in  (vld[k]),
                .nin       (stg[k][NIN-1:0]),
                .valid_out (vld[k+1]),
                .nout      (stg[k+1][NOUT-1:0])
            );
            assign stg[k+1][CELLS-1:NOUT] = '0;
        end
    endgenerate

    rt_readout u_out (
        .clk        (clk),
        .rst        (rst),
        .root_valid (vld[LEVELS]),
        .root       (stg[LEVELS][0]),
        .done       (done),
        .count      (count),
        .any        (any),
        .sel_out    (sel_out),
        .rd_valid   (rd_valid),
        .rd_val     (rd_val),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi)
    );

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!done && count == '0 && sel_out == '0));

endmodule

// File: tb/rt_select_tree_test.sv
module rt_select_tree_test;
    import rtree_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start = 1'b0;
    logic [CELLS-1:0]       sel_in = '0;
    logic [CELLS*VAL_W-1:0] cell_val = '0;
    logic [CELLS*IDX_W-1:0] cell_lo = '0;
    logic [CELLS*IDX_W-1:0] cell_hi = '0;
    logic                   done, any, rd_valid;
    logic [CNT_W-1:0]       count;
    logic [CELLS-1:0]       sel_out;
    logic [VAL_W-1:0]       rd_val;
    logic [IDX_W-1:0]       rd_lo, rd_hi;

    rt_select_tree uut (.*);

    always #2 clk = ~clk;

    typedef struct {
        int               due;
        int               cnt;
        bit               anyb;
        logic [CELLS-1:0] mask;
        logic [VAL_W-1:0] v;
        logic [IDX_W-1:0] lo;
        logic [IDX_W-1:0] hi;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // Reference model: record an expected result for every issue
    always @(posedge clk) begin
        if (!rst && start) begin
            exp_t e;
            int   first;
            e.due  = cyc + LEVELS;
            e.cnt  = 0;
            first  = -1;
            for (int i = 0; i < CELLS; i++) begin
                if (sel_in[i]) begin
                    e.cnt++;
                    if (first < 0) first = i;
                end
            end
            e.anyb = (first >= 0);
            e.mask = '0;
            e.v    = '0;
            e.lo   = '0;
            e.hi   = '0;
            if (first >= 0) begin
                e.mask[first] = 1'b1;
                e.v  = cell_val[first*VAL_W +: VAL_W];
                e.lo = cell_lo[first*IDX_W +: IDX_W];
                e.hi = cell_hi[first*IDX_W +: IDX_W];
            end
            exp_q.push_back(e);
        end
        cyc = cyc + 1;
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            chk(done == 1'b0 && count == '0 && sel_out == '0 && !any && !rd_valid,
                "R7", "reset state", {done, any, rd_valid, count}, 64'h0);
        end else if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(done == 1'b1, "R6", "done at issue+latency", done, 1);
            chk(count == CNT_W'(e.cnt), "R1", "count", count, e.cnt);
            chk(sel_out == e.mask, "R2", "sel_out", sel_out, e.mask);
            chk(any == e.anyb, "R3", "any", any, e.anyb);
            if (e.anyb) begin
                chk(rd_valid && rd_val == e.v && rd_lo == e.lo && rd_hi == e.hi, "R4",
                    "read-out {valid,val,lo,hi}", {rd_valid, rd_val, rd_lo, rd_hi},
                    {1'b1, e.v, e.lo, e.hi});
            end else begin
                chk(!rd_valid && rd_val == '0 && rd_lo == '0 && rd_hi == '0 && sel_out == '0,
                    "R5", "none result", {rd_valid, rd_val, rd_lo, rd_hi}, 64'h0);
            end
        end else begin
            chk(done == 1'b0, "R8", "done without issue", done, 0);
        end
    end

    task automatic drive(input logic [CELLS-1:0] m, input bit st);
        @(negedge clk);
        sel_in = m;
        for (int i = 0; i < CELLS; i++) begin
            cell_val[i*VAL_W +: VAL_W] = VAL_W'($urandom);
            cell_lo[i*IDX_W +: IDX_W]  = IDX_W'($urandom);
            cell_hi[i*IDX_W +: IDX_W]  = IDX_W'($urandom);
        end
        start = st;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(CELLS'($urandom), 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R5: empty vector
        drive('0, 1'b1);
        // R4: only cell 0, only last cell
        drive(CELLS'(1), 1'b1);
        drive(CELLS'(1) << (CELLS - 1), 1'b1);
        // R1: all ones gives CELLS
        drive('1, 1'b1);
        idle(LEVELS + 2);
        // R2: several bits, leftmost kept
        drive(CELLS'(8'hA0), 1'b1);
        idle(2);
        drive(CELLS'(8'h06), 1'b1);
        idle(1);
        // R6: long back-to-back burst of mixed patterns
        for (int i = 0; i < 40; i++) drive(CELLS'($urandom), 1'b1);
        // R8: inputs move while start low
        idle(20);
        for (int i = 0; i < 60; i++) drive(CELLS'($urandom), ($urandom % 2) == 1);
        drive('0, 1'b0);
        idle(LEVELS + 3);
        if (exp_q.size() != 0)
            chk(1'b0, "R6", "results still pending", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule